// File: doc/BRIEF.md
# CAN Error Status Tracker

This block holds the status state of a CAN controller. The protocol engine sends it single-cycle event pulses: a clean reception, a transmission that was acknowledged, a detected error with its type, and the start of each frame. The block also watches the engine's current transmit and receive error counters. From these inputs it keeps two sticky success flags, a code for the first error seen in the current frame, a warning flag and a bus-off flag. The status is shown as one byte.

While bus-off is set, the transmit driver is disabled, so the node floats its transmit line. Software reads the status byte and clears the success flags by writing zeros to their bit positions. An external recovery request ends bus-off. In the cycle of that request the block raises a strobe that tells the engine to zero both error counters.

Top module: `can_err_status`

## Requirements
- R1: `busOff` (status bit 7) sets on the clock edge after the transmit or the receive error counter is at or above 256. While it is set, `txEnable` is 0.
- R2: `busOff` clears only on a clock edge where `recoverReq` is high while `busOff` is set. In that cycle `cntClear` is high combinationally, and the recovery wins over a set condition in the same cycle. `cntClear` is 0 whenever `busOff` is clear.
- R3: The warning flag (status bit 6) sets on the edge after either counter is at or above 96. It clears on the edge after both counters are below 96.
- R4: The receive-OK flag (status bit 4) sets on the edge after an `rxOkPulse` and holds until software clears it.
- R5: The transmit-OK flag (status bit 3) sets on the edge after a `txOkPulse` and holds until software clears it.
- R6: A write (`regWrEn` high) with data bit 4 at 0 clears receive-OK, and with data bit 3 at 0 clears transmit-OK. Writing 1 to either bit leaves it as it is. A set pulse in the same cycle wins over the clear. Write data in bits 7, 6, 5 and 2:0 has no effect.
- R7: Status bits 2:0 take the `errType` of the first `errPulse` after a `sofPulse` or after reset. Later errors are ignored until the next `sofPulse`. A `sofPulse` alone keeps the stored code. Codes: 000 none, 001 stuff, 010 form, 011 acknowledgment, 100 bit-1, 101 bit-0, 110 CRC, 111 unused.
- R8: An `errPulse` in the same cycle as a `sofPulse` is captured as the first error of the new frame.
- R9: Status bit 5 always reads 0.
- R10: After reset the status byte is 0x00 and `txEnable` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| rxOkPulse | input | 1 | Frame received without error |
| txOkPulse | input | 1 | Frame sent without error and acknowledged |
| errPulse | input | 1 | Error detected on the bus |
| errType | input | 3 | Type code of the error in `errPulse` |
| sofPulse | input | 1 | Start of a new frame |
| txErrCnt | input | CNT_W | Transmit error counter |
| rxErrCnt | input | CNT_W | Receive error counter |
| recoverReq | input | 1 | Request to end bus-off |
| regWrEn | input | 1 | Software write strobe |
| regWrData | input | 8 | Software write data |
| statusByte | output | 8 | Status byte |
| txEnable | output | 1 | Transmit driver enable, 0 while bus-off |
| cntClear | output | 1 | Strobe telling the engine to zero both counters |

## Verification
The assertions assume that the event inputs are single-cycle pulses. They also assume that `errType` carries a code from 1 to 6 whenever `errPulse` is high, and that the engine zeroes its counters after `cntClear`. The stimulus table drives every input again each cycle and only uses valid error codes. After each recovery it brings the counters below 96, so the warning assertions see the counters the engine would produce.

// File: rtl/can_err_pkg.sv
package can_err_pkg;

  typedef enum logic [2:0] {
    ERR_NONE  = 3'd0,
    ERR_STUFF = 3'd1,
    ERR_FORM  = 3'd2,
    ERR_ACK   = 3'd3,
    ERR_BIT1  = 3'd4,
    ERR_BIT0  = 3'd5,
    ERR_CRC   = 3'd6,
    ERR_UNUSED = 3'd7
  } errCode_e;

  localparam int RX_BIT = 4;
  localparam int TX_BIT = 3;

  typedef struct packed {
    logic setRx;
    logic clrRx;
    logic setTx;
    logic clrTx;
    logic capErr;
    logic setOff;
    logic clrOff;
    logic warnNext;
  } strobe_t;

endpackage

// File: rtl/can_err_ctrl.sv
module can_err_ctrl
  import can_err_pkg::*;
#(
  parameter int CNT_W = 9,
  parameter int WARN_LIMIT = 96,
  parameter int OFF_LIMIT = 256
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rxOkPulse,
  input  logic             txOkPulse,
  input  logic             errPulse,
  input  logic             sofPulse,
  input  logic [CNT_W-1:0] txErrCnt,
  input  logic [CNT_W-1:0] rxErrCnt,
  input  logic             recoverReq,
  input  logic             regWrEn,
  input  logic [7:0]       regWrData,
  input  logic             busOff,
  output strobe_t          strobe
);

  localparam logic [CNT_W:0] WARN_V = (CNT_W+1)'(WARN_LIMIT);
  localparam logic [CNT_W:0] OFF_V  = (CNT_W+1)'(OFF_LIMIT);

  logic armed;
  logic txHigh, rxHigh, txWarn, rxWarn;

  assign txHigh = {1'b0, txErrCnt} >= OFF_V;
  assign rxHigh = {1'b0, rxErrCnt} >= OFF_V;
  assign txWarn = {1'b0, txErrCnt} >= WARN_V;
  assign rxWarn = {1'b0, rxErrCnt} >= WARN_V;

  always_comb begin
    strobe          = '0;
    strobe.setRx    = rxOkPulse;
    strobe.setTx    = txOkPulse;
    strobe.clrRx    = regWrEn && !regWrData[RX_BIT];
    strobe.clrTx    = regWrEn && !regWrData[TX_BIT];
    strobe.capErr   = errPulse && (armed || sofPulse);
    strobe.clrOff   = recoverReq && busOff;
    strobe.setOff   = txHigh || rxHigh;
    strobe.warnNext = txWarn || rxWarn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              armed <= 1'b1;
    else if (strobe.capErr) armed <= 1'b0;
    else if (sofPulse)      armed <= 1'b1;
  end

  // R7: once the latch is spent, an error without a new frame start is not captured
  a_r7_no_recapture: assert property (@(posedge clk) disable iff (!rstN)
    (!armed && !sofPulse) |-> !strobe.capErr);

endmodule

// File: rtl/can_err_dpath.sv
module can_err_dpath
  import can_err_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  strobe_t    strobe,
  input  logic [2:0] errType,
  output logic       busOff,
  output logic       warn,
  output logic       rxOk,
  output logic       txOk,
  output logic [2:0] lastErr
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busOff  <= 1'b0;
      warn    <= 1'b0;
      rxOk    <= 1'b0;
      txOk    <= 1'b0;
      lastErr <= ERR_NONE;
    end else begin
      warn <= strobe.warnNext;
      if (strobe.clrOff)      busOff <= 1'b0;
      else if (strobe.setOff) busOff <= 1'b1;
      if (strobe.setRx)       rxOk <= 1'b1;
      else if (strobe.clrRx)  rxOk <= 1'b0;
      if (strobe.setTx)       txOk <= 1'b1;
      else if (strobe.clrTx)  txOk <= 1'b0;
      if (strobe.capErr)      lastErr <= errType;
    end
  end

  // R6: a set pulse beats a simultaneous clear
  a_r6_set_wins_rx: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.setRx && strobe.clrRx) |=> rxOk);
  a_r6_set_wins_tx: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.setTx && strobe.clrTx) |=> txOk);

endmodule

// File: rtl/can_err_status.sv
module can_err_status
  import can_err_pkg::*;
#(
  parameter int CNT_W = 9,
  parameter int WARN_LIMIT = 96,
  parameter int OFF_LIMIT = 256
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rxOkPulse,
  input  logic             txOkPulse,
  input  logic             errPulse,
  input  logic [2:0]       errType,
  input  logic             sofPulse,
  input  logic [CNT_W-1:0] txErrCnt,
  input  logic [CNT_W-1:0] rxErrCnt,
  input  logic             recoverReq,
  input  logic             regWrEn,
  input  logic [7:0]       regWrData,
  output logic [7:0]       statusByte,
  output logic             txEnable,
  output logic             cntClear
);

  strobe_t    strobe;
  logic       busOff, warn, rxOk, txOk;
  logic [2:0] lastErr;

  can_err_ctrl #(
    .CNT_W(CNT_W), .WARN_LIMIT(WARN_LIMIT), .OFF_LIMIT(OFF_LIMIT)
  ) u_ctrl (
    .clk(clk), .rstN(rstN),
    .rxOkPulse(rxOkPulse), .txOkPulse(txOkPulse),
    .errPulse(errPulse), .sofPulse(sofPulse),
    .txErrCnt(txErrCnt), .rxErrCnt(rxErrCnt),
    .recoverReq(recoverReq), .regWrEn(regWrEn), .regWrData(regWrData),
    .busOff(busOff), .strobe(strobe)
  );

  can_err_dpath u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .errType(errType),
    .busOff(busOff), .warn(warn), .rxOk(rxOk), .txOk(txOk),
    .lastErr(lastErr)
  );

  assign statusByte = {busOff, warn, 1'b0, rxOk, txOk, lastErr};
  assign txEnable   = !busOff;
  assign cntClear   = strobe.clrOff;

  localparam logic [CNT_W:0] OFF_V  = (CNT_W+1)'(OFF_LIMIT);
  localparam logic [CNT_W:0] WARN_V = (CNT_W+1)'(WARN_LIMIT);

  // R1: a counter at the limit without recovery leads to bus-off and a floated driver
  a_r1_enter_off: assert property (@(posedge clk) disable iff (!rstN)
    (({1'b0, rxErrCnt} >= OFF_V || {1'b0, txErrCnt} >= OFF_V) && !recoverReq)
    |=> (statusByte[7] && !txEnable));
  // R2: bus-off stays until recovery; recovery drops it and zeroes counters
  a_r2_off_holds: assert property (@(posedge clk) disable iff (!rstN)
    (statusByte[7] && !recoverReq) |=> statusByte[7]);
  a_r2_recover: assert property (@(posedge clk) disable iff (!rstN)
    cntClear |=> (!statusByte[7] && txEnable));
  // R3: warning follows the counters
  a_r3_warn_clear: assert property (@(posedge clk) disable iff (!rstN)
    ({1'b0, rxErrCnt} < WARN_V && {1'b0, txErrCnt} < WARN_V) |=> !statusByte[6]);
  // R4, R5: success pulses always show up
  a_r4_rx_set: assert property (@(posedge clk) disable iff (!rstN)
    rxOkPulse |=> statusByte[4]);
  a_r5_tx_set: assert property (@(posedge clk) disable iff (!rstN)
    txOkPulse |=> statusByte[3]);
  // R7: without an error the code does not move
  a_r7_code_stable: assert property (@(posedge clk) disable iff (!rstN)
    !errPulse |=> $stable(statusByte[2:0]));
  // R9: reserved bit
  a_r9_reserved: assert property (@(posedge clk) disable iff (!rstN)
    !statusByte[5]);

endmodule

// File: tb/can_err_status_tb.sv
`timescale 1ns/1ps
module can_err_status_tb;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       rxOkPulse = 0, txOkPulse = 0, errPulse = 0, sofPulse = 0;
  logic [2:0] errType = 0;
  logic [8:0] txErrCnt = 0, rxErrCnt = 0;
  logic       recoverReq = 0, regWrEn = 0;
  logic [7:0] regWrData = 0;
  logic [7:0] statusByte;
  logic       txEnable, cntClear;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  can_err_status u_dut (
    .clk(clk), .rstN(rstN), .rxOkPulse(rxOkPulse), .txOkPulse(txOkPulse),
    .errPulse(errPulse), .errType(errType), .sofPulse(sofPulse),
    .txErrCnt(txErrCnt), .rxErrCnt(rxErrCnt), .recoverReq(recoverReq),
    .regWrEn(regWrEn), .regWrData(regWrData), .statusByte(statusByte),
    .txEnable(txEnable), .cntClear(cntClear)
  );

  typedef struct packed {
    logic       rx;
    logic       tx;
    logic       err;
    logic [2:0] et;
    logic       sof;
    logic [8:0] txc;
    logic [8:0] rxc;
    logic       wr;
    logic [7:0] wd;
    logic       rec;
    logic [7:0] expStat;
    logic       expTxEn;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VEC [NV] = '{
    '{1'b1,1'b0,1'b0,3'd0,1'b0,9'd0,  9'd0,  1'b0,8'h00,1'b0,8'h10,1'b1}, // R4
    '{1'b0,1'b1,1'b0,3'd0,1'b0,9'd0,  9'd0,  1'b0,8'h00,1'b0,8'h18,1'b1}, // R5
    '{1'b0,1'b0,1'b1,3'd1,1'b0,9'd0,  9'd0,  1'b0,8'h00,1'b0,8'h19,1'b1}, // R7 stuff
    '{1'b0,1'b0,1'b1,3'd2,1'b0,9'd0,  9'd0,  1'b0,8'h00,1'b0,8'h19,1'b1}, // R7 ignored
    '{1'b0,1'b0,1'b0,3'd0,1'b0,9'd0,  9'd0,  1'b1,8'hEF,1'b0,8'h09,1'b1}, // R6 clear rx
    '{1'b0,1'b0,1'b0,3'd0,1'b1,9'd0,  9'd0,  1'b0,8'h00,1'b0,8'h09,1'b1}, // R7 sof keeps
    '{1'b0,1'b0,1'b1,3'd6,1'b0,9'd0,  9'd0,  1'b1,8'hF7,1'b0,8'h06,1'b1}, // R7 crc, R6 clear tx
    '{1'b1,1'b0,1'b0,3'd0,1'b0,9'd0,  9'd0,  1'b1,8'h00,1'b0,8'h16,1'b1}, // R6 set wins
    '{1'b0,1'b0,1'b0,3'd0,1'b0,9'd96, 9'd0,  1'b0,8'h00,1'b0,8'h56,1'b1}, // R3 tx warn
    '{1'b0,1'b0,1'b0,3'd0,1'b0,9'd95, 9'd96, 1'b0,8'h00,1'b0,8'h56,1'b1}, // R3 rx warn
    '{1'b0,1'b0,1'b0,3'd0,1'b0,9'd0,  9'd0,  1'b0,8'h00,1'b0,8'h16,1'b1}, // R3 clear
    '{1'b0,1'b0,1'b1,3'd3,1'b1,9'd0,  9'd0,  1'b0,8'h00,1'b0,8'h13,1'b1}, // R8
    '{1'b0,1'b0,1'b0,3'd0,1'b0,9'd0,  9'd256,1'b0,8'h00,1'b0,8'hD3,1'b0}, // R1
    '{1'b0,1'b0,1'b0,3'd0,1'b0,9'd0,  9'd0,  1'b0,8'h00,1'b0,8'h93,1'b0}, // R2 holds
    '{1'b0,1'b0,1'b0,3'd0,1'b0,9'd0,  9'd0,  1'b0,8'h00,1'b1,8'h13,1'b1}, // R2 recover
    '{1'b0,1'b0,1'b0,3'd0,1'b0,9'd0,  9'd0,  1'b1,8'hE7,1'b0,8'h03,1'b1}  // R6, R9
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    rxOkPulse = 0; txOkPulse = 0; errPulse = 0; errType = 0; sofPulse = 0;
    recoverReq = 0; regWrEn = 0; regWrData = 0;
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R10 status", statusByte, 8'h00);
    check("R10 txEnable", txEnable, 1);
    rstN = 1'b1;
    @(posedge clk); #1;

    for (int i = 0; i < NV; i++) begin
      rxOkPulse = VEC[i].rx; txOkPulse = VEC[i].tx;
      errPulse = VEC[i].err; errType = VEC[i].et; sofPulse = VEC[i].sof;
      txErrCnt = VEC[i].txc; rxErrCnt = VEC[i].rxc;
      regWrEn = VEC[i].wr; regWrData = VEC[i].wd; recoverReq = VEC[i].rec;
      @(posedge clk); #1;
      check($sformatf("R1-vector %0d status", i), statusByte, VEC[i].expStat);
      check($sformatf("R1 vector %0d txEnable", i), txEnable, VEC[i].expTxEn);
    end
    idle();

    // R2: recovery without bus-off does nothing
    recoverReq = 1; #1;
    check("R2 no clear when not off", cntClear, 0);
    @(posedge clk); #1;
    idle();

    // R1: transmit counter at 256 enters bus-off
    txErrCnt = 9'd256;
    @(posedge clk); #1;
    check("R1 tx bus-off", statusByte[7], 1);
    check("R1 tx float", txEnable, 0);
    // R2: recovery while counter still high wins
    recoverReq = 1; #1;
    check("R2 cntClear strobe", cntClear, 1);
    @(posedge clk); #1;
    recoverReq = 0; txErrCnt = 9'd0;
    check("R2 recovery wins", statusByte[7], 0);
    check("R2 tx re-enabled", txEnable, 1);
    @(posedge clk); #1;
    check("R3 warn gone", statusByte[6], 0);

    // R7: bit-0 error after new frame, then more errors ignored
    sofPulse = 1; @(posedge clk); #1; idle();
    errPulse = 1; errType = 3'd5; @(posedge clk); #1; idle();
    errPulse = 1; errType = 3'd4; @(posedge clk); #1; idle();
    check("R7 first error kept", statusByte[2:0], 3'd5);

    // R10: reset mid-run clears everything
    rxOkPulse = 1; @(posedge clk); #1; idle();
    rstN = 0; #1;
    check("R10 async reset", statusByte, 8'h00);
    @(posedge clk); #1;
    rstN = 1;
    @(posedge clk); #1;
    check("R9 reserved zero", statusByte[5], 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule